// File: doc/BRIEF.md
# USB Bus Line-Condition Detector

This block watches the sampled full-speed data-line state of a USB device port and turns conditions that last long enough into single-cycle events. An unbroken stretch of single-ended zero (SE0) yields a bus-reset event. An unbroken stretch of idle (J) yields a suspend event. While the device state logic reports that the port is suspended, a move off J onto K or onto SE0 yields a resume event. Time is measured in cycles of a known system clock. The two lengths are parameters: `RESET_CYC` is short (2.5 us of clock cycles) and `SUSPEND_CYC` is long (3 ms of clock cycles).

A resume event sets a latched interrupt flag. Software clears the flag by writing 0 to it. A clear made while the clock is marked as stopped also locks the flag, and the flag then ignores resume events until software writes 1.

Three small state machines do the work. Each duration timer has the states `DT_IDLE`, `DT_COUNT` and `DT_DONE`:
- `DT_IDLE` to `DT_COUNT`: the condition appears.
- `DT_COUNT` to `DT_DONE`: the count reaches its threshold, and the event pulses.
- Any state to `DT_IDLE`: the condition breaks.

The resume watcher has the states `RS_OFF_J` and `RS_ON_J`, and it follows whether the line was J at the last edge.

The flag has the states `FLG_ARMED`, `FLG_RAISED` and `FLG_LOCKED`:
- `FLG_ARMED` to `FLG_RAISED`: a resume event arrives.
- `FLG_RAISED` to `FLG_ARMED`: software writes 0 with the clock running.
- `FLG_RAISED` or `FLG_ARMED` to `FLG_LOCKED`: software writes 0 with the clock stopped.
- `FLG_LOCKED` to `FLG_ARMED`: software writes 1.

Top module: `usb_line_cond_det`

## Requirements
- R1: `line_st` is encoded as SE0 = 2'b00, J = 2'b01, K = 2'b10 and SE1 = 2'b11. When SE0 is sampled on `RESET_CYC` consecutive clock edges, `bus_reset_evt` is high for the cycle after the last of those edges.
- R2: When J is sampled on `SUSPEND_CYC` consecutive edges, `suspend_evt` is high for the cycle after the last of those edges.
- R3: Any other line value restarts the count for a condition, and SE1 restarts both counts. A fresh run must then reach the full threshold again.
- R4: Each event pulses for one cycle only, once per unbroken occurrence, however long the condition lasts.
- R5: While `dev_suspended` is high, a sample of K or SE0 that directly follows a sample of J drives `resume_evt` high for the cycle after that edge.
- R6: No resume event is raised when `dev_suspended` is low, or when the previous sample was not J.
- R7: `resume_irq` rises one cycle after a `resume_evt` pulse and stays high until it is cleared.
- R8: A write (`wr_en` high) with `wr_data` 0 clears `resume_irq` at that edge. A write of 1 leaves the flag unchanged.
- R9: A write of 0 while `clk_stopped` is high locks the flag: it then ignores resume events until a write of 1. That write re-arms the flag but does not set it.
- R10: When a resume event and a clear meet at the same edge, the event wins and `resume_irq` is 1 afterwards.
- R11: After reset all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_st | input | 2 | Sampled line state (SE0/J/K/SE1) |
| dev_suspended | input | 1 | Device state logic reports the port is suspended |
| clk_stopped | input | 1 | Clock is considered stopped for flag clears |
| wr_en | input | 1 | Software write strobe for the resume flag |
| wr_data | input | 1 | Value written to the resume flag |
| bus_reset_evt | output | 1 | Single-cycle bus-reset event |
| suspend_evt | output | 1 | Single-cycle suspend event |
| resume_evt | output | 1 | Single-cycle resume event |
| resume_irq | output | 1 | Latched resume interrupt flag |

## Verification
The bench holds SE0 and J for runs longer than their thresholds. This separates the exact firing cycle from a repeat pulse. Runs cut short by SE1 and by K show whether the count restarts or merely pauses. Resume is tried from J to K and from J to SE0 with the port suspended. It is also tried from J to K while not suspended and from K to SE0 while suspended, which separates the transition rule from a plain edge detector. The flag is cleared with the clock running and with it stopped, re-armed by a write of 1, and cleared at the same edge as an event, which shows the lock and the set priority.

// File: rtl/usb_lcd_pkg.sv
package usb_lcd_pkg;
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        DT_IDLE  = 2'b00,
        DT_COUNT = 2'b01,
        DT_DONE  = 2'b10
    } dur_state_e;

    typedef enum logic {
        RS_OFF_J = 1'b0,
        RS_ON_J  = 1'b1
    } rs_state_e;

    typedef enum logic [1:0] {
        FLG_ARMED  = 2'b00,
        FLG_RAISED = 2'b01,
        FLG_LOCKED = 2'b10
    } flg_state_e;
endpackage

// File: rtl/usb_lcd_dur_timer.sv
module usb_lcd_dur_timer
    import usb_lcd_pkg::*;
#(
    parameter int unsigned THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic fire
);
    localparam int unsigned CW = (THRESH < 2) ? 1 : $clog2(THRESH + 1);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

    dur_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DT_IDLE: begin
                if (cond) begin
                    cnt_d   = CW'(1);
                    state_d = (THRESH <= 1) ? DT_DONE : DT_COUNT;
                end
            end
            DT_COUNT: begin
                if (!cond) begin
                    state_d = DT_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = DT_DONE;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            DT_DONE: begin
                if (!cond) begin
                    state_d = DT_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = DT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fire <= 1'b0;
        else        fire <= (state_q != DT_DONE) && (state_d == DT_DONE);
    end
endmodule

// File: rtl/usb_lcd_resume_watch.sv
module usb_lcd_resume_watch
    import usb_lcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_e line,
    input  logic  suspended,
    output logic  resume_evt
);
    rs_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RS_OFF_J: state_d = (line == LS_J) ? RS_ON_J : RS_OFF_J;
            RS_ON_J:  state_d = (line == LS_J) ? RS_ON_J : RS_OFF_J;
            default:  state_d = RS_OFF_J;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_OFF_J;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resume_evt <= 1'b0;
        else        resume_evt <= (state_q == RS_ON_J) && suspended &&
                                  ((line == LS_K) || (line == LS_SE0));
    end
endmodule

// File: rtl/usb_lcd_resume_flag.sv
module usb_lcd_resume_flag
    import usb_lcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr_en,
    input  logic wr_data,
    input  logic clk_stopped,
    output logic flag
);
    flg_state_e state_q, state_d;
    logic clr, rearm;

    assign clr   = wr_en && !wr_data;
    assign rearm = wr_en && wr_data;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_ARMED: begin
                if (set_evt)                 state_d = FLG_RAISED;
                else if (clr && clk_stopped) state_d = FLG_LOCKED;
            end
            FLG_RAISED: begin
                if (set_evt)  state_d = FLG_RAISED;
                else if (clr) state_d = clk_stopped ? FLG_LOCKED : FLG_ARMED;
            end
            FLG_LOCKED: begin
                if (rearm) state_d = FLG_ARMED;
            end
            default: state_d = FLG_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_ARMED;
        else        state_q <= state_d;
    end

    always_comb flag = (state_q == FLG_RAISED);
endmodule

// File: rtl/usb_line_cond_det.sv
module usb_line_cond_det
    import usb_lcd_pkg::*;
#(
    parameter int unsigned RESET_CYC   = 120,
    parameter int unsigned SUSPEND_CYC = 144000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_st,
    input  logic       dev_suspended,
    input  logic       clk_stopped,
    input  logic       wr_en,
    input  logic       wr_data,
    output logic       bus_reset_evt,
    output logic       suspend_evt,
    output logic       resume_evt,
    output logic       resume_irq
);
    line_e line;
    assign line = line_e'(line_st);

    usb_lcd_dur_timer #(.THRESH(RESET_CYC)) u_se0_timer (
        .clk(clk), .rst_n(rst_n), .cond(line == LS_SE0), .fire(bus_reset_evt)
    );

    usb_lcd_dur_timer #(.THRESH(SUSPEND_CYC)) u_idle_timer (
        .clk(clk), .rst_n(rst_n), .cond(line == LS_J), .fire(suspend_evt)
    );

    usb_lcd_resume_watch u_resume (
        .clk(clk), .rst_n(rst_n), .line(line),
        .suspended(dev_suspended), .resume_evt(resume_evt)
    );

    usb_lcd_resume_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(resume_evt),
        .wr_en(wr_en), .wr_data(wr_data), .clk_stopped(clk_stopped),
        .flag(resume_irq)
    );
endmodule

// File: rtl/usb_lcd_checker.sv
module usb_lcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_st,
    input logic       dev_suspended,
    input logic       wr_en,
    input logic       wr_data,
    input logic       bus_reset_evt,
    input logic       suspend_evt,
    input logic       resume_evt,
    input logic       resume_irq
);
    AST_RST_NEEDS_SE0: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |-> ($past(line_st) == 2'b00)); // R1
    AST_SUSP_NEEDS_J: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_evt |-> ($past(line_st) == 2'b01)); // R2
    AST_RST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_evt |=> !bus_reset_evt); // R4
    AST_SUSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_evt |=> !suspend_evt); // R4
    AST_RES_ONLY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt |-> ($past(dev_suspended) &&
                        (($past(line_st) == 2'b10) || ($past(line_st) == 2'b00)))); // R6
    AST_FLAG_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_irq) |-> $past(resume_evt)); // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data && !resume_evt) |=> !resume_irq); // R8
endmodule

bind usb_line_cond_det usb_lcd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .line_st(line_st), .dev_suspended(dev_suspended),
    .wr_en(wr_en), .wr_data(wr_data), .bus_reset_evt(bus_reset_evt),
    .suspend_evt(suspend_evt), .resume_evt(resume_evt), .resume_irq(resume_irq)
);

// File: tb/usb_line_cond_det_bench.sv
module usb_line_cond_det_bench;
    localparam int unsigned RST_N_CYC = 6;
    localparam int unsigned SUS_N_CYC = 15;
    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;
    localparam logic [3:0] NONE = 4'b0000, RST = 4'b1000, SUS = 4'b0100,
                           RES = 4'b0010, IRQ = 4'b0001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] line_st = K;
    logic dev_suspended = 1'b0, clk_stopped = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
    logic bus_reset_evt, suspend_evt, resume_evt, resume_irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    usb_line_cond_det #(.RESET_CYC(RST_N_CYC), .SUSPEND_CYC(SUS_N_CYC)) u_usb_line_cond_det (
        .clk(clk), .rst_n(rst_n), .line_st(line_st), .dev_suspended(dev_suspended),
        .clk_stopped(clk_stopped), .wr_en(wr_en), .wr_data(wr_data),
        .bus_reset_evt(bus_reset_evt), .suspend_evt(suspend_evt),
        .resume_evt(resume_evt), .resume_irq(resume_irq)
    );

    // Monitor: two time units after each edge, compare against the oldest expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = {bus_reset_evt, suspend_evt, resume_evt, resume_irq};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: outputs {rst,susp,res,irq} = %b, expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: inputs applied at the falling edge, expectation for the next rising edge queued.
    task automatic step(input logic [1:0] l, input logic s, input logic we, input logic wd,
                        input logic co, input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        line_st = l; dev_suspended = s; wr_en = we; wr_data = wd; clk_stopped = co;
        it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic hold(input logic [1:0] l, input logic s, input int n, input logic [3:0] base,
                        input int k, input logic [3:0] firebits, input string tag);
        for (int i = 1; i <= n; i++)
            step(l, s, 1'b0, 1'b0, 1'b0, (i == k) ? (base | firebits) : base, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(K, 0, 0, 0, 0, NONE, "R11 reset state");
        step(K, 0, 0, 0, 0, NONE, "R11 reset state");
        // R1 / R4: long SE0, single pulse after the 6th edge
        hold(SE0, 0, 10, NONE, RST_N_CYC, RST, "R1 R4 SE0 run");
        step(K, 0, 0, 0, 0, NONE, "R3 break");
        // R3: SE1 restarts the count
        hold(SE0, 0, 5, NONE, 0, NONE, "R3 short SE0");
        step(SE1, 0, 0, 0, 0, NONE, "R3 SE1 break");
        hold(SE0, 0, 6, NONE, RST_N_CYC, RST, "R3 fresh SE0 run");
        step(K, 0, 0, 0, 0, NONE, "R3 break");
        // R2 / R4: long idle
        hold(J, 0, 18, NONE, SUS_N_CYC, SUS, "R2 R4 idle run");
        step(K, 0, 0, 0, 0, NONE, "R6 J->K not suspended");
        // R5 / R7: J->K while suspended
        hold(J, 1, 3, NONE, 0, NONE, "R5 J prefix");
        step(K, 1, 0, 0, 0, RES, "R5 J->K resume");
        step(K, 1, 0, 0, 0, IRQ, "R7 flag rises");
        hold(K, 1, 3, IRQ, 0, NONE, "R7 flag holds");
        // R8
        step(K, 1, 1, 1, 0, IRQ, "R8 write 1 no effect");
        step(K, 1, 1, 0, 0, NONE, "R8 write 0 clears");
        // R5: J->SE0
        hold(J, 1, 2, NONE, 0, NONE, "R5 J prefix");
        step(SE0, 1, 0, 0, 0, RES, "R5 J->SE0 resume");
        step(K, 1, 0, 0, 0, IRQ, "R7 flag rises");
        // R6: K->SE0 while suspended
        step(SE0, 1, 0, 0, 0, IRQ, "R6 K->SE0 no resume");
        step(K, 1, 0, 0, 0, IRQ, "R6 SE0->K no resume");
        step(K, 1, 1, 0, 0, NONE, "R8 clear");
        // R10: event and clear at the same edge
        hold(J, 1, 2, NONE, 0, NONE, "R10 J prefix");
        step(K, 1, 0, 0, 0, RES, "R5 resume");
        step(K, 1, 1, 0, 0, IRQ, "R10 set beats clear");
        step(K, 1, 1, 0, 0, NONE, "R8 clear");
        // R9: clear with clock stopped locks the flag
        step(K, 1, 1, 0, 1, NONE, "R9 lock clear");
        hold(J, 1, 2, NONE, 0, NONE, "R9 J prefix");
        step(K, 1, 0, 0, 0, RES, "R5 resume while locked");
        step(K, 1, 0, 0, 0, NONE, "R9 locked ignores event");
        step(K, 1, 0, 0, 0, NONE, "R9 locked ignores event");
        step(K, 1, 1, 1, 0, NONE, "R9 rearm does not set");
        hold(J, 1, 2, NONE, 0, NONE, "R9 J prefix");
        step(K, 1, 0, 0, 0, RES, "R5 resume after rearm");
        step(K, 1, 0, 0, 0, IRQ, "R9 rearmed flag rises");
        step(K, 0, 0, 0, 0, IRQ, "R7 flag holds");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: bench hung, actual timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule